// File: doc/BRIEF.md
# Lockable Controller Configuration Register

This block is a single 32-bit configuration word for a host-controller function. Software reads and writes it through a plain register port. The word holds four kinds of content:

- read/write policy fields;
- a write-once lock bit that can freeze a parameter-selected subset of those fields;
- a sticky hardware error flag that software clears by writing 1;
- a read-only interrupt-pin field copied from an external input.

The block also owns the system-error path for two internal error sources. The first is an unsupported posted request. The second is a master/target abort condition. Each source has its own enable bit in the word. When its enable is set and the global system-error enable is high, the source drives the `serr_o` output. Any assertion of `serr_o` latches a sticky system-error status bit, and a separate clear port resets that bit. Bus decoding and error detection sit outside this block.

Top module: `ctl_cfg_reg`

## Requirements
- R1: After reset the read value is 32'h0000_0000 with bits 3:0 replaced by `int_pin_i`. At that point `serr_o` and `sse_o` are 0.
- R2: Read bits 3:0 always equal `int_pin_i`. Read bits 18:4 always read zero, and writes to bits 18:0 have no effect.
- R3: While unlocked, a write loads bit 24 (abort report enable), bit 22 (unsupported report enable), bits 30:25 (spare) and bits 21:19 (timeout select) from the write data. The new value is visible in the cycle after the write.
- R4: Bit 31 (lock) takes the write data's bit 31 on the first write after reset. Every later write leaves it unchanged.
- R5: While bit 31 reads 1, writes leave unchanged every read/write bit that is covered by the LOCK_MASK parameter. By default LOCK_MASK covers bits 30:19.
- R6: Bit 23 (unsupported-request flag) reads 1 in the cycle after `unsup_req_i` is high, and it then holds.
- R7: A write with data bit 23 = 1 clears the flag. Data bit 23 = 0 leaves the flag unchanged. The lock never blocks this clear.
- R8: If `unsup_req_i` and a clearing write occur in the same cycle, the flag reads 1 afterwards.
- R9: In the same cycle, `serr_o` = `serr_en_i` AND ((bit 22 AND bit 23) OR (bit 24 AND `abort_err_i`)).
- R10: `sse_o` reads 1 in the cycle after `serr_o` is high, and it holds until a cycle with `sse_clr_i` high. If `serr_o` and `sse_clr_i` are high together, `sse_o` is set.
- R11: Reset returns the lock to 0 and re-arms its write-once capability.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_data | input | 32 | Write data |
| cfg_rd_data | output | 32 | Current register value |
| int_pin_i | input | 4 | Interrupt pin value mirrored into bits 3:0 |
| unsup_req_i | input | 1 | Unsupported posted request pulse |
| abort_err_i | input | 1 | Master/target abort error condition |
| serr_en_i | input | 1 | Global system-error reporting enable |
| sse_clr_i | input | 1 | Clear strobe for the system-error status bit |
| serr_o | output | 1 | System-error output |
| sse_o | output | 1 | Sticky system-error status |

## Verification
The assertions check these properties on every cycle:
- the read-only field and the zero bits;
- the lock bit staying frozen once the first write has consumed it;
- locked fields holding across writes;
- the flag setting after a request pulse and holding without a clear;
- the status bit following `serr_o`;
- `serr_o` staying low without the global enable.

Some behaviour can only be shown by the bench's scenarios:
- the write-once rule re-arming after a mid-run reset;
- the flag clear being honoured while locked;
- set-over-clear priority for both sticky bits;
- the exact combination of both error sources with their enables.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
    localparam int REG_W    = 32;
    localparam int PIN_W    = 4;
    localparam int LOCK_BIT = 31;
    localparam int ABRT_BIT = 24;
    localparam int FLAG_BIT = 23;
    localparam int UREN_BIT = 22;
    // plain read/write bits: 30:24 and 22:19
    localparam logic [REG_W-1:0] RW_MASK = 32'h7F78_0000;

    typedef struct packed {
        logic lock;
        logic armed;
    } lock_state_t;

    typedef struct packed {
        logic flag;
        logic sse;
    } err_state_t;

    typedef struct packed {
        logic [REG_W-1:0] rw;
    } fld_state_t;
endpackage

// File: rtl/ccr_lock_unit.sv
module ccr_lock_unit
    import ccr_pkg::*;
#(
    parameter logic [REG_W-1:0] LOCK_MASK = 32'h7FF8_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_lock,
    output logic             lock_o,
    output logic [REG_W-1:0] fld_wmask_o
);
    lock_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && st_q.armed) begin
            st_d.lock  = wr_lock;
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{lock: 1'b0, armed: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign lock_o      = st_q.lock;
    assign fld_wmask_o = wr_en ? (RW_MASK & ~(st_q.lock ? LOCK_MASK : '0)) : '0;
endmodule

// File: rtl/ccr_err_unit.sv
module ccr_err_unit
    import ccr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic unsup_req_i,
    input  logic flag_clr,
    input  logic uren,
    input  logic abrt_en,
    input  logic abort_err_i,
    input  logic serr_en_i,
    input  logic sse_clr_i,
    output logic flag_o,
    output logic serr_o,
    output logic sse_o
);
    err_state_t st_d, st_q;
    logic       serr_w;

    always_comb begin
        serr_w = serr_en_i & ((uren & st_q.flag) | (abrt_en & abort_err_i));
        st_d   = st_q;
        if (unsup_req_i)   st_d.flag = 1'b1;
        else if (flag_clr) st_d.flag = 1'b0;
        if (serr_w)         st_d.sse = 1'b1;
        else if (sse_clr_i) st_d.sse = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;
    assign serr_o = serr_w;
    assign sse_o  = st_q.sse;
endmodule

// File: rtl/ctl_cfg_reg.sv
module ctl_cfg_reg
    import ccr_pkg::*;
#(
    parameter logic [31:0] LOCK_MASK = 32'h7FF8_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr_en,
    input  logic [31:0] cfg_wr_data,
    output logic [31:0] cfg_rd_data,
    input  logic [3:0]  int_pin_i,
    input  logic        unsup_req_i,
    input  logic        abort_err_i,
    input  logic        serr_en_i,
    input  logic        sse_clr_i,
    output logic        serr_o,
    output logic        sse_o
);
    fld_state_t       fld_d, fld_q;
    logic [REG_W-1:0] wmask;
    logic             lock_w;
    logic             flag_w;

    ccr_lock_unit #(.LOCK_MASK(LOCK_MASK)) u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cfg_wr_en),
        .wr_lock     (cfg_wr_data[LOCK_BIT]),
        .lock_o      (lock_w),
        .fld_wmask_o (wmask)
    );

    ccr_err_unit u_err (
        .clk         (clk),
        .rst_n       (rst_n),
        .unsup_req_i (unsup_req_i),
        .flag_clr    (cfg_wr_en & cfg_wr_data[FLAG_BIT]),
        .uren        (fld_q.rw[UREN_BIT]),
        .abrt_en     (fld_q.rw[ABRT_BIT]),
        .abort_err_i (abort_err_i),
        .serr_en_i   (serr_en_i),
        .sse_clr_i   (sse_clr_i),
        .flag_o      (flag_w),
        .serr_o      (serr_o),
        .sse_o       (sse_o)
    );

    always_comb begin
        fld_d    = fld_q;
        fld_d.rw = (fld_q.rw & ~wmask) | (cfg_wr_data & wmask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fld_q <= '0;
        end else begin
            fld_q <= fld_d;
        end
    end

    always_comb begin
        cfg_rd_data                 = fld_q.rw;
        cfg_rd_data[LOCK_BIT]       = lock_w;
        cfg_rd_data[FLAG_BIT]       = flag_w;
        cfg_rd_data[PIN_W-1:0]      = int_pin_i;
    end
endmodule

// File: rtl/ccr_checker.sv
module ccr_checker
    import ccr_pkg::*;
#(
    parameter logic [31:0] LOCK_MASK = 32'h7FF8_0000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr_en,
    input logic [31:0] cfg_wr_data,
    input logic [31:0] cfg_rd_data,
    input logic [3:0]  int_pin_i,
    input logic        unsup_req_i,
    input logic        serr_en_i,
    input logic        serr_o,
    input logic        sse_o
);
    logic seen_wr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) seen_wr_q <= 1'b0;
        else if (cfg_wr_en) seen_wr_q <= 1'b1;
    end

    AST_RO_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd_data[18:0] == {15'b0, int_pin_i}); // R2
    AST_LOCK_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        seen_wr_q |=> $stable(cfg_rd_data[LOCK_BIT])); // R4
    AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd_data[LOCK_BIT] && cfg_wr_en |=>
        ((cfg_rd_data ^ $past(cfg_rd_data)) & LOCK_MASK & RW_MASK) == '0); // R5
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        unsup_req_i |=> cfg_rd_data[FLAG_BIT]); // R6
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !unsup_req_i && !(cfg_wr_en && cfg_wr_data[FLAG_BIT]) |=> $stable(cfg_rd_data[FLAG_BIT])); // R7
    AST_SERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !serr_en_i |-> !serr_o); // R9
    AST_SSE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        serr_o |=> sse_o); // R10
endmodule

bind ctl_cfg_reg ccr_checker #(.LOCK_MASK(LOCK_MASK)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_data (cfg_wr_data),
    .cfg_rd_data (cfg_rd_data),
    .int_pin_i   (int_pin_i),
    .unsup_req_i (unsup_req_i),
    .serr_en_i   (serr_en_i),
    .serr_o      (serr_o),
    .sse_o       (sse_o)
);

// File: tb/tb_ctl_cfg_reg.sv
module tb_ctl_cfg_reg;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYC   = 20000;
    localparam int NVEC       = 6;
    // each entry: {write data, expected read with pin value 4'hD}
    localparam logic [63:0] VEC [NVEC] = '{
        {32'h0000_0000, 32'h0000_000D},
        {32'hFFFF_FFFF, 32'h7F78_000D},
        {32'h5555_5555, 32'h5550_000D},
        {32'hAAAA_AAAA, 32'h2A28_000D},
        {32'h1234_5678, 32'h1230_000D},
        {32'h00F8_0000, 32'h0078_000D}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic [31:0] cfg_rd_data;
    logic [3:0]  int_pin_i = 4'hD;
    logic        unsup_req_i = 1'b0;
    logic        abort_err_i = 1'b0;
    logic        serr_en_i = 1'b0;
    logic        sse_clr_i = 1'b0;
    logic        serr_o;
    logic        sse_o;
    int          total = 0;
    int          bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctl_cfg_reg dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_data(cfg_rd_data), .int_pin_i(int_pin_i), .unsup_req_i(unsup_req_i),
        .abort_err_i(abort_err_i), .serr_en_i(serr_en_i), .sse_clr_i(sse_clr_i),
        .serr_o(serr_o), .sse_o(sse_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one cycle of stimulus, removed at the next falling edge
    task automatic cyc(input logic we, input logic [31:0] d, input logic ur, input logic clr);
        @(negedge clk);
        cfg_wr_en = we; cfg_wr_data = d; unsup_req_i = ur; sse_clr_i = clr;
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_wr_data = '0; unsup_req_i = 1'b0; sse_clr_i = 1'b0;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        do_reset();
        chk("R1 reset value", cfg_rd_data, 32'h0000_000D);
        chk("R1 serr at reset", {31'b0, serr_o}, 32'd0);
        chk("R1 sse at reset", {31'b0, sse_o}, 32'd0);

        // R3 field writes while unlocked; first entry consumes the lock with 0
        for (int i = 0; i < NVEC; i++) begin
            cyc(1'b1, VEC[i][63:32], 1'b0, 1'b0);
            chk("R3 table write", cfg_rd_data, VEC[i][31:0]);
        end

        int_pin_i = 4'h3; #1;
        chk("R2 pin mirror", cfg_rd_data, 32'h0078_0003);
        int_pin_i = 4'hD; #1;

        cyc(1'b1, 32'h0000_0000, 1'b0, 1'b0);
        chk("R3 clear fields", cfg_rd_data, 32'h0000_000D);
        cyc(1'b0, 32'h0, 1'b1, 1'b0);
        chk("R6 flag set", cfg_rd_data, 32'h0080_000D);
        cyc(1'b1, 32'h0000_0000, 1'b0, 1'b0);
        chk("R7 write 0 keeps flag", cfg_rd_data, 32'h0080_000D);
        cyc(1'b1, 32'h0080_0000, 1'b0, 1'b0);
        chk("R7 write 1 clears flag", cfg_rd_data, 32'h0000_000D);
        cyc(1'b1, 32'h0080_0000, 1'b1, 1'b0);
        chk("R8 set beats clear", cfg_rd_data, 32'h0080_000D);

        cyc(1'b1, 32'h0040_0000, 1'b0, 1'b0);
        chk("R3 report enable", cfg_rd_data, 32'h00C0_000D);
        @(negedge clk); serr_en_i = 1'b1; #1;
        chk("R9 serr from flag", {31'b0, serr_o}, 32'd1);
        @(negedge clk); #1;
        chk("R10 sse set", {31'b0, sse_o}, 32'd1);
        serr_en_i = 1'b0; #1;
        chk("R9 serr needs global enable", {31'b0, serr_o}, 32'd0);
        @(negedge clk); #1;
        chk("R10 sse sticky", {31'b0, sse_o}, 32'd1);
        cyc(1'b0, 32'h0, 1'b0, 1'b1);
        chk("R10 sse cleared", {31'b0, sse_o}, 32'd0);
        @(negedge clk); serr_en_i = 1'b1; sse_clr_i = 1'b1;
        @(negedge clk); serr_en_i = 1'b0; sse_clr_i = 1'b0; #1;
        chk("R10 set beats clear", {31'b0, sse_o}, 32'd1);
        cyc(1'b0, 32'h0, 1'b0, 1'b1);

        cyc(1'b1, 32'h0180_0000, 1'b0, 1'b0);
        chk("R3 abort enable", cfg_rd_data, 32'h0100_000D);
        @(negedge clk); abort_err_i = 1'b1; serr_en_i = 1'b1; #1;
        chk("R9 serr from abort", {31'b0, serr_o}, 32'd1);
        serr_en_i = 1'b0; #1;
        chk("R9 abort gated", {31'b0, serr_o}, 32'd0);
        cyc(1'b1, 32'h0000_0000, 1'b0, 1'b0);
        serr_en_i = 1'b1; #1;
        chk("R9 abort without enable bit", {31'b0, serr_o}, 32'd0);
        @(negedge clk); abort_err_i = 1'b0; serr_en_i = 1'b0;
        cyc(1'b0, 32'h0, 1'b0, 1'b1);
        chk("R10 sse cleared after abort", {31'b0, sse_o}, 32'd0);

        do_reset();
        chk("R11 reset clears", cfg_rd_data, 32'h0000_000D);
        cyc(1'b1, 32'h8A00_0000, 1'b0, 1'b0);
        chk("R4 lock loaded", cfg_rd_data, 32'h8A00_000D);
        cyc(1'b1, 32'h7F78_0000, 1'b0, 1'b0);
        chk("R5 locked fields", cfg_rd_data, 32'h8A00_000D);
        cyc(1'b1, 32'h0000_0000, 1'b0, 1'b0);
        chk("R4 lock write once", cfg_rd_data, 32'h8A00_000D);
        cyc(1'b0, 32'h0, 1'b1, 1'b0);
        cyc(1'b1, 32'h0080_0000, 1'b0, 1'b0);
        chk("R7 clear while locked", cfg_rd_data, 32'h8A00_000D);

        do_reset();
        cyc(1'b1, 32'h8000_0000, 1'b0, 1'b0);
        chk("R11 write once re-armed", cfg_rd_data, 32'h8000_000D);
        cyc(1'b1, 32'h0000_0000, 1'b0, 1'b0);
        chk("R4 lock stays", cfg_rd_data, 32'h8000_000D);

        finish_run();
    end
endmodule